// File: doc/BRIEF.md
# Pitch-Synchronous Overlap-Add Engine

This block is the time-domain back end of a concatenative speech synthesiser. Decoded pitch periods of L samples are written into a local frame store. A stream of 3-byte script words then drives the synthesis. For each word the engine assembles a two-period segment from the named frame and the frame after it, and can play that segment backwards. At a unit boundary it can add a linear correction ramp. It then multiplies the segment by a Hanning window and sums it into a circular output queue at the current head.

Once the segment is summed, the engine streams out as many finished samples as the word requests, over a valid/ready port. Each emitted slot is cleared to zero and the head moves past it. The shift count of each word therefore sets the spacing between successive periods, and that spacing controls pitch and duration. The engine processes one segment sample per clock. It accepts a new word only when the previous shift-out has finished.

Top module: `psola_ola_engine`

## Requirements
- R1: After a synchronous active-low reset, `scr_ready` is 1, `out_valid` is 0 and every queue slot holds zero.
- R2: A script word with frame index f builds a segment of 2L samples: position k < L is frame f sample k, and position k ≥ L is frame (f+1) mod NFRAMES sample k−L. The frame index is `scr_data[7:0]`, reduced modulo NFRAMES.
- R3: When the reverse flag `scr_data[23]` is 1, segment position k takes the sample that R2 gives for position 2L−1−k.
- R4: When the boundary flag `scr_data[22]` is 1, the step s in `scr_data[21:16]` (6-bit two's complement) adds s·k to the sample at position k. The position is counted after any reversal, and the sum saturates to signed 16 bits.
- R5: Each sample is multiplied by the Q15 coefficient w[k] = round(32767·0.5·(1−cos(2π(k+0.5)/2L))). The product is rounded by adding 2^14 and shifting right arithmetically by 15.
- R6: The windowed sample at position k is added into queue slot (head+k) mod 4L, and the sum saturates to the signed 16-bit range.
- R7: After the overlap-add, exactly `scr_data[15:8]` samples are emitted in queue order starting at the head, and the head advances by that count. A count of 0 emits nothing and returns the engine to idle.
- R8: Every emitted slot is set to zero. A shift count larger than the queue therefore emits zeros for slots that were already drained.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold. `scr_ready` is 0 from the cycle after a word is accepted until its last sample has been emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_we | input | 1 | Frame store write enable |
| frm_addr | input | FBITS+LBITS | Frame store address: frame number, then sample offset |
| frm_data | input | 16 | Signed sample to store |
| scr_valid | input | 1 | Script word offered |
| scr_ready | output | 1 | Engine idle, word will be taken |
| scr_data | input | 24 | Script word: reverse, boundary, step, shift count, frame index |
| out_valid | output | 1 | Output sample available |
| out_ready | input | 1 | Consumer takes the sample |
| out_data | output | 16 | Signed output sample |

## Verification
The assertions assume that the frame store is not written while a segment is being summed. They also assume that `scr_valid` is only looked at while the engine is idle. The bench loads frames only between script words. It presents each word only after it has seen `scr_ready` high at a falling edge. Random traffic draws frame indices, flags, signed steps and shift counts up to three queue lengths under random back-pressure. Directed words cover full-scale frames, where the correction ramp and the queue sums must saturate, and also a zero shift and an over-long shift.

// File: rtl/psola_pkg.sv
// Shared helpers for the overlap-add engine: window coefficient formula
// and signed saturation. Assumes 16-bit signed samples throughout.
package psola_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_SUM, ST_EMIT} eng_state_t;

    // Q15 Hanning coefficient for position n of a segment of length len.
    function automatic int hann_q15(int n, int len);
        real ang;
        ang = 2.0 * 3.14159265358979 * (real'(n) + 0.5) / real'(len);
        return $rtoi(32767.0 * 0.5 * (1.0 - $cos(ang)) + 0.5);
    endfunction

    // Clamp an 18-bit signed value into the signed 16-bit range.
    function automatic logic signed [15:0] sat16(logic signed [17:0] v);
        if (v > 18'sd32767)       return 16'sh7fff;
        else if (v < -18'sd32768) return 16'sh8000;
        else                      return v[15:0];
    endfunction

endpackage

// File: rtl/psola_win_rom.sv
// Window coefficient ROM: 2^SBITS Q15 Hanning coefficients computed at
// elaboration. Assumes the index is already a segment position.
module psola_win_rom #(
    parameter int SBITS = 4
) (
    input  logic [SBITS-1:0] idx,
    output logic [15:0]      coef
);
    import psola_pkg::*;
    localparam int SEG = 1 << SBITS;

    logic [15:0] tbl [SEG];

    for (genvar g = 0; g < SEG; g++) begin : g_coef
        localparam int CVAL = hann_q15(g, SEG);
        assign tbl[g] = 16'(CVAL);
    end

    // Table lookup.
    always_comb coef = tbl[idx];
endmodule

// File: rtl/psola_seg_shaper.sv
// Sample shaper: applies the optional boundary ramp and then the window
// to one segment sample. Purely combinational; assumes coef <= 32767.
module psola_seg_shaper #(
    parameter int SBITS = 4
) (
    input  logic signed [15:0] x_in,
    input  logic               bnd,
    input  logic signed [5:0]  step,
    input  logic [SBITS-1:0]   pos,
    input  logic [15:0]        coef,
    output logic signed [15:0] y_out
);
    import psola_pkg::*;
    localparam int PW = SBITS + 7;

    logic signed [PW-1:0] corr;
    logic signed [15:0]   x_adj;
    logic signed [32:0]   prod;
    logic signed [32:0]   rnd;

    // Ramp term s*k and saturating add.
    always_comb begin
        corr  = PW'(step) * $signed({1'b0, pos});
        x_adj = bnd ? sat16(18'(x_in) + 18'(corr)) : x_in;
    end

    // Q15 multiply with round-half-up.
    always_comb begin
        prod  = 33'(x_adj) * $signed({17'd0, coef});
        rnd   = prod + 33'sd16384;
        y_out = rnd[30:15];
    end

    always_comb assert (coef <= 16'd32767) else $error("a_r5_coef_q15 range");
endmodule

// File: rtl/psola_ola_queue.sv
// Circular output queue with a saturating accumulate port and a clear
// port. Assumes the two ports are never active in the same cycle.
module psola_ola_queue #(
    parameter int QBITS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic [QBITS-1:0]   acc_addr,
    input  logic signed [15:0] acc_val,
    input  logic               clr_en,
    input  logic [QBITS-1:0]   clr_addr,
    input  logic [QBITS-1:0]   rd_addr,
    output logic signed [15:0] rd_data
);
    import psola_pkg::*;
    localparam int QLEN = 1 << QBITS;

    logic signed [15:0] slot [QLEN];

    // Storage update: reset, accumulate or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < QLEN; i++) slot[i] <= '0;
        end else if (acc_en) begin
            slot[acc_addr] <= sat16(18'(slot[acc_addr]) + 18'(acc_val));
        end else if (clr_en) begin
            slot[clr_addr] <= '0;
        end
    end

    // Read port.
    always_comb rd_data = slot[rd_addr];

    a_r8_slot_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> slot[$past(clr_addr)] == 16'sd0);
    a_r6_ports_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && clr_en));
endmodule

// File: rtl/psola_ola_engine.sv
// Pitch-synchronous overlap-add engine (top). Holds the frame store,
// sequences one segment sample per clock into the queue, then streams
// out the requested number of samples. Assumes the frame store is
// written only while idle.
module psola_ola_engine #(
    parameter int LBITS = 3,
    parameter int FBITS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frm_we,
    input  logic [FBITS+LBITS-1:0] frm_addr,
    input  logic [15:0]            frm_data,
    input  logic                   scr_valid,
    output logic                   scr_ready,
    input  logic [23:0]            scr_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [15:0]            out_data
);
    import psola_pkg::*;
    localparam int SBITS = LBITS + 1;
    localparam int QBITS = LBITS + 2;
    localparam int SEG   = 1 << SBITS;
    localparam int FDEPTH = 1 << (FBITS + LBITS);

    eng_state_t         state;
    logic [FBITS-1:0]   fidx;
    logic [7:0]         left;
    logic               rev, bnd;
    logic signed [5:0]  step;
    logic [SBITS-1:0]   k;
    logic [QBITS-1:0]   head;
    logic signed [15:0] fmem [FDEPTH];

    logic [SBITS-1:0]   src;
    logic [FBITS-1:0]   fsel;
    logic signed [15:0] x_raw, y_win, q_rd;
    logic [15:0]        coef;
    logic               do_sum, do_emit;

    // Frame store write port.
    always_ff @(posedge clk) begin
        if (frm_we) fmem[frm_addr] <= frm_data;
    end

    // Segment sample fetch with optional reversal.
    always_comb begin
        src   = rev ? ~k : k;
        fsel  = src[LBITS] ? fidx + 1'b1 : fidx;
        x_raw = fmem[{fsel, src[LBITS-1:0]}];
    end

    psola_win_rom #(.SBITS(SBITS)) u_rom (.idx(k), .coef(coef));

    psola_seg_shaper #(.SBITS(SBITS)) u_shape (
        .x_in(x_raw), .bnd(bnd), .step(step), .pos(k), .coef(coef), .y_out(y_win)
    );

    // Handshake and queue strobes.
    always_comb begin
        scr_ready = (state == ST_IDLE);
        out_valid = (state == ST_EMIT);
        do_sum    = (state == ST_SUM);
        do_emit   = out_valid && out_ready;
        out_data  = q_rd;
    end

    psola_ola_queue #(.QBITS(QBITS)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .acc_en(do_sum), .acc_addr(head + QBITS'(k)), .acc_val(y_win),
        .clr_en(do_emit), .clr_addr(head),
        .rd_addr(head), .rd_data(q_rd)
    );

    // Sequencer: accept word, sum segment, emit shift samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            head  <= '0;
            k     <= '0;
            left  <= '0;
            fidx  <= '0;
            rev   <= 1'b0;
            bnd   <= 1'b0;
            step  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (scr_valid) begin
                    fidx  <= scr_data[FBITS-1:0];
                    left  <= scr_data[15:8];
                    rev   <= scr_data[23];
                    bnd   <= scr_data[22];
                    step  <= scr_data[21:16];
                    k     <= '0;
                    state <= ST_SUM;
                end
                ST_SUM: begin
                    k <= k + 1'b1;
                    if (k == SBITS'(SEG - 1))
                        state <= (left == 8'd0) ? ST_IDLE : ST_EMIT;
                end
                default: if (out_ready) begin
                    head <= head + 1'b1;
                    left <= left - 1'b1;
                    if (left == 8'd1) state <= ST_IDLE;
                end
            endcase
        end
    end

    a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        scr_valid && scr_ready |=> !scr_ready);
    a_r7_head_steps: assert property (@(posedge clk) disable iff (!rst_n)
        do_emit |=> head == $past(head) + 1'b1);
    a_r7_emit_excludes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && scr_ready));
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> scr_ready && !out_valid);
endmodule

// File: tb/psola_ola_engine_test.sv
`timescale 1ns/1ps
module psola_ola_engine_test;
    localparam int LBITS = 3, FBITS = 4;
    localparam int L = 1 << LBITS, SEG = 2 * L, Q = 4 * L, NF = 1 << FBITS;

    logic clk = 0, rst_n = 0;
    logic frm_we = 0;
    logic [FBITS+LBITS-1:0] frm_addr = '0;
    logic [15:0] frm_data = '0;
    logic scr_valid = 0, scr_ready, out_valid, out_ready = 1;
    logic [23:0] scr_data = '0;
    logic [15:0] out_data;

    int n_chk = 0, n_bad = 0, cyc = 0, mh = 0;
    int fm [NF*L];
    int qm [Q];
    bit bp = 0;

    always #2.5 clk = ~clk;

    psola_ola_engine #(.LBITS(LBITS), .FBITS(FBITS)) uut (.*);

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d exp=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat(int v);
        return v > 32767 ? 32767 : (v < -32768 ? -32768 : v);
    endfunction

    function automatic int win(int n);
        real a;
        a = 2.0 * 3.14159265358979 * (real'(n) + 0.5) / real'(SEG);
        return $rtoi(32767.0 * 0.5 * (1.0 - $cos(a)) + 0.5);
    endfunction

    task automatic load(int f, int i, int v);
        @(negedge clk);
        frm_we = 1; frm_addr = (FBITS+LBITS)'(f * L + i); frm_data = 16'(v);
        fm[f*L+i] = v;
        @(negedge clk);
        frm_we = 0;
    endtask

    // Model of R2..R6 applied to the queue mirror.
    task automatic model_sum(int f, bit rv, bit bd, int st);
        for (int k = 0; k < SEG; k++) begin
            int src, fr, x;
            longint p;
            src = rv ? SEG - 1 - k : k;
            fr  = (src < L) ? f % NF : (f + 1) % NF;
            x   = fm[fr*L + src % L];
            if (bd) x = sat(x + st * k);
            p = longint'(x) * win(k) + 16384;
            qm[(mh+k)%Q] = sat(int'(p >>> 15));
        end
    endtask

    task automatic run(int f, int sh, bit rv, bit bd, int st, string tag);
        int n, guard, held;
        bit hv;
        while (!scr_ready) @(negedge clk);
        scr_data = {rv, bd, 6'(st), 8'(sh), 8'(f)};
        scr_valid = 1;
        for (int k = 0; k < SEG; k++) begin
            int a;
            a = (mh + k) % Q;
            qm[a] = qm[a];
        end
        begin
            int tmp [Q];
            tmp = qm;
            model_sum(f, rv, bd, st);
            for (int k = 0; k < SEG; k++) begin
                int a;
                a = (mh + k) % Q;
                qm[a] = sat(tmp[a] + qm[a]);
            end
            for (int j = 0; j < Q; j++) begin
                bit inwin;
                inwin = ((j - mh + Q) % Q) < SEG;
                if (!inwin) qm[j] = tmp[j];
            end
        end
        @(negedge clk);
        scr_valid = 0;
        chk("R9 busy after accept", scr_ready, 0);
        n = 0; guard = 0; hv = 0; held = 0;
        if (sh == 0) begin
            while (!scr_ready && guard < 100) begin
                chk("R7 zero shift emits nothing", out_valid, 0);
                @(negedge clk); guard++;
            end
        end
        while (n < sh && guard < 5000) begin
            if (hv) begin
                chk("R9 valid held", out_valid, 1);
                chk("R9 data held", int'($signed(out_data)), held);
            end
            out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
            hv = 0;
            if (out_valid && out_ready) begin
                chk(tag, int'($signed(out_data)), qm[mh]);
                qm[mh] = 0; mh = (mh + 1) % Q; n++;
            end else if (out_valid) begin
                hv = 1; held = int'($signed(out_data));
            end
            @(negedge clk); guard++;
        end
        out_ready = 1;
        chk("R7 idle after shift", scr_ready, 1);
        chk("R7 no extra sample", out_valid, 0);
    endtask

    initial begin
        void'($urandom(32'd7));
        for (int i = 0; i < Q; i++) qm[i] = 0;
        repeat (3) @(negedge clk);
        chk("R1 scr_ready", scr_ready, 1);
        chk("R1 out_valid", out_valid, 0);
        rst_n = 1;
        for (int f = 0; f < NF; f++)
            for (int i = 0; i < L; i++) load(f, i, int'($urandom % 16001) - 8000);
        // Reset queue is zero: first emission is pure windowed segment.
        run(2, L, 0, 0, 0, "R2 R5 R1 plain segment");
        run(NF - 1, L, 1, 0, 0, "R3 reversed, frame wrap R2");
        run(4, L, 0, 1, -5, "R4 ramp step -5");
        run(7, 0, 0, 0, 0, "R7 zero shift");
        run(8, 3, 1, 1, 17, "R6 overlap after zero shift");
        run(9, 2*L, 0, 0, 0, "R7 flush");
        // Saturation: full-scale frames.
        for (int i = 0; i < L; i++) begin load(5, i, 32767); load(6, i, 32767); end
        run(5, 0, 0, 1, 31, "R4 ramp saturates");
        run(5, 0, 0, 0, 0, "R6 stack");
        run(5, 5*L, 0, 0, 0, "R6 saturated sum, R8 drained zeros");
        for (int i = 0; i < L; i++) begin load(5, i, -32768); load(6, i, -32768); end
        run(5, 1, 0, 0, 0, "R6 neg");
        run(5, 4*L, 1, 0, 0, "R6 negative saturation R8");
        bp = 1;
        for (int t = 0; t < 60; t++)
            run($urandom % 256, $urandom % (3*Q), $urandom % 2, $urandom % 2,
                int'($urandom % 64) - 32, "R2 R3 R4 R6 R7 random");
        run(0, 5*Q, 0, 0, 0, "R8 long drain");
        summary();
        $finish;
    end
endmodule